// File: doc/BRIEF.md
# Packet Acknowledge Retransmit Controller

This block runs one node's side of the acknowledged packet exchange on a bus with two redundant paths. When the node sends an information packet, the block locks the path picked for it. Once the send finishes, it counts down an acknowledge window. The outcome is one of three results:

- a positive acknowledge ends the transfer;
- a negative acknowledge, or an empty window, asks for the same packet to be sent again;
- too many resends end the transfer as a failure.

On the receive side, the block decides the reply to each incoming information packet from two checks: whether the packet arrived intact and whether it was stored. The reply is a one-cycle request raised on the cycle after the packet. It goes out in the quiet slot reserved for the answering node, without arbitrating for the bus.

The window length is an input, in clock units. It is compared with the minimum the bus timing allows: the quiet slot plus the turnaround time plus the time to verify an acknowledge. A window that is too short raises a configuration error flag.

Top module: `pkt_ack_ctrl`

## Requirements
- R1: A cycle with `rx_pkt_valid` high and both `rx_crc_ok` and `rx_stored_ok` high gives a one-cycle `send_ack` pulse on the following cycle, with `send_nak` low.
- R2: A cycle with `rx_pkt_valid` high, `rx_crc_ok` high and `rx_stored_ok` low gives a one-cycle `send_nak` pulse on the following cycle, with `send_ack` low.
- R3: A cycle with `rx_pkt_valid` high and `rx_crc_ok` low gives no reply: `send_ack` and `send_nak` both stay low on the following cycle.
- R4: An `ack_stb` that arrives while the acknowledge window is open gives a one-cycle `xfer_done` pulse on the next cycle. `path_hold` falls on that same cycle.
- R5: A `nak_stb` that arrives while the window is open, and below the retry limit, gives a one-cycle `retransmit_req` on the next cycle. The block then waits for a new `tx_done`, with `path_hold` still high and `held_path` unchanged.
- R6: With window length T (T ≥ 2), if no strobe arrives, `retransmit_req` rises exactly T cycles after the cycle in which `tx_done` was sampled, and not before.
- R7: `tx_start` latches `tx_path_sel` into `held_path` and raises `path_hold`. Both stay unchanged until the transfer completes or fails. A `tx_start` that arrives while a transfer is in progress is ignored.
- R8: An `ack_stb` or `nak_stb` that arrives while the block is idle, or while the packet is still being sent (before `tx_done`), has no effect on any output.
- R9: `cfg_err` is high exactly when `ack_timeout` ≤ QS_CLKS + TURN_CLKS + VERIFY_CLKS (15 with the default parameters).
- R10: After MAX_RETRY retransmits of one packet (3 by default), the next NAK or expiry gives a one-cycle `xfer_fail` pulse instead of `retransmit_req`, and `path_hold` drops. A new `tx_start` clears the retry count.
- R11: When `ack_stb` coincides with `nak_stb`, or with the last cycle of the window, the ACK wins: `xfer_done` pulses and `retransmit_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_start | input | 1 | Begin sending a new information packet |
| tx_path_sel | input | 1 | Path chosen for this transfer (0 or 1) |
| tx_done | input | 1 | Packet send has finished on the bus |
| ack_timeout | input | TW (16) | Acknowledge window length in clock units |
| rx_pkt_valid | input | 1 | An information packet was received this cycle |
| rx_crc_ok | input | 1 | The received packet passed its CRC |
| rx_stored_ok | input | 1 | The received packet was accepted and stored |
| ack_stb | input | 1 | Positive acknowledge received |
| nak_stb | input | 1 | Negative acknowledge received |
| send_ack | output | 1 | Send a positive acknowledge in the quiet slot |
| send_nak | output | 1 | Send a negative acknowledge in the quiet slot |
| retransmit_req | output | 1 | Resend the same packet |
| xfer_done | output | 1 | Transfer acknowledged |
| xfer_fail | output | 1 | Retry limit exceeded |
| path_hold | output | 1 | A transfer owns its path |
| held_path | output | 1 | Path owned by the current transfer |
| cfg_err | output | 1 | Window length is too short for the bus timing |

## Verification
Two things can resolve a transfer in the same cycle: an arriving acknowledge, and the expiry of the window (or an arriving NAK).

The bench provokes the first case by counting T-1 cycles after `tx_done` and then raising `ack_stb` on the final cycle of the window. It provokes the second case by raising `ack_stb` and `nak_stb` together. In both cases it requires `xfer_done` and no `retransmit_req`.

A reply generated for a received packet can also overlap a pending transfer. That overlap is judged by requiring the reply pulses to depend only on the receive inputs.

// File: rtl/pac_pkg.sv
package pac_pkg;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_SEND = 2'd1,
        TX_WAIT = 2'd2
    } tx_state_e;

    typedef enum logic [1:0] {
        RSP_NONE = 2'd0,
        RSP_ACK  = 2'd1,
        RSP_NAK  = 2'd2
    } reply_e;

    typedef struct packed {
        logic done;
        logic retx;
        logic fail;
    } outcome_t;

    function automatic reply_e pick_reply(input logic crc_good, input logic stored);
        if (!crc_good)
            return RSP_NONE;
        return stored ? RSP_ACK : RSP_NAK;
    endfunction

endpackage

// File: rtl/pac_reply_gen.sv
module pac_reply_gen
    import pac_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pkt_valid,
    input  logic crc_good,
    input  logic stored,
    output logic reply_ack,
    output logic reply_nak
);
    reply_e reply_q;

    always_ff @(posedge clk) begin
        if (rst)
            reply_q <= RSP_NONE;
        else if (pkt_valid)
            reply_q <= pick_reply(crc_good, stored);
        else
            reply_q <= RSP_NONE;
    end

    assign reply_ack = (reply_q == RSP_ACK);
    assign reply_nak = (reply_q == RSP_NAK);

    p_ack_reply_r1: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && crc_good && stored) |=> (reply_ack && !reply_nak));
    p_nak_reply_r2: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && crc_good && !stored) |=> (reply_nak && !reply_ack));
    p_crc_silent_r3: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !crc_good) |=> (!reply_ack && !reply_nak));
    p_no_unprompted_r3: assert property (@(posedge clk) disable iff (rst)
        !pkt_valid |=> (!reply_ack && !reply_nak));

endmodule

// File: rtl/pac_cfg_check.sv
module pac_cfg_check #(
    parameter int TW          = 16,
    parameter int QS_CLKS     = 7,
    parameter int TURN_CLKS   = 4,
    parameter int VERIFY_CLKS = 4
) (
    input  logic [TW-1:0] timeout_len,
    output logic          too_short
);
    localparam int             FLOOR_I = QS_CLKS + TURN_CLKS + VERIFY_CLKS;
    localparam logic [TW-1:0]  FLOOR   = TW'(FLOOR_I);

    assign too_short = (timeout_len <= FLOOR);

    always_comb begin
        if (!$isunknown(timeout_len))
            a_cfg_floor_r9: assert (too_short == (int'(timeout_len) <= FLOOR_I));
    end

endmodule

// File: rtl/pac_tx_tracker.sv
module pac_tx_tracker
    import pac_pkg::*;
#(
    parameter int TW        = 16,
    parameter int MAX_RETRY = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          path_sel,
    input  logic          send_done,
    input  logic [TW-1:0] timeout_len,
    input  logic          ack_in,
    input  logic          nak_in,
    output outcome_t      outcome,
    output logic          busy,
    output logic          path_q
);
    localparam int             RW      = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);
    localparam logic [RW-1:0]  RETRY_M = RW'(MAX_RETRY);

    tx_state_e     state_q;
    logic [TW-1:0] cnt_q;
    logic [RW-1:0] retry_q;
    logic          expire;

    assign expire = (cnt_q <= TW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TX_IDLE;
            cnt_q   <= '0;
            retry_q <= '0;
            path_q  <= 1'b0;
            outcome <= '0;
        end else begin
            outcome <= '0;
            case (state_q)
                TX_IDLE: begin
                    if (start) begin
                        state_q <= TX_SEND;
                        path_q  <= path_sel;
                        retry_q <= '0;
                    end
                end
                TX_SEND: begin
                    if (send_done) begin
                        state_q <= TX_WAIT;
                        cnt_q   <= timeout_len;
                    end
                end
                TX_WAIT: begin
                    if (ack_in) begin
                        outcome.done <= 1'b1;
                        state_q      <= TX_IDLE;
                    end else if (nak_in || expire) begin
                        if (retry_q == RETRY_M) begin
                            outcome.fail <= 1'b1;
                            state_q      <= TX_IDLE;
                        end else begin
                            outcome.retx <= 1'b1;
                            retry_q      <= retry_q + RW'(1);
                            state_q      <= TX_SEND;
                        end
                    end else begin
                        cnt_q <= cnt_q - TW'(1);
                    end
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    assign busy = (state_q != TX_IDLE);

    p_outcome_excl_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(outcome));
    p_ack_wins_r11: assert property (@(posedge clk) disable iff (rst)
        (state_q == TX_WAIT && ack_in) |=> (outcome.done && !busy));
    p_ignore_stray_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q != TX_WAIT) |=> (outcome == '0));
    p_path_stable_r7: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || $stable(path_q)));
    p_fail_limit_r10: assert property (@(posedge clk) disable iff (rst)
        outcome.fail |-> (retry_q == RETRY_M && !busy));
    p_retx_resend_r5: assert property (@(posedge clk) disable iff (rst)
        outcome.retx |-> (state_q == TX_SEND));

endmodule

// File: rtl/pkt_ack_ctrl.sv
module pkt_ack_ctrl
    import pac_pkg::*;
#(
    parameter int TW          = 16,
    parameter int QS_CLKS     = 7,
    parameter int TURN_CLKS   = 4,
    parameter int VERIFY_CLKS = 4,
    parameter int MAX_RETRY   = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tx_start,
    input  logic          tx_path_sel,
    input  logic          tx_done,
    input  logic [TW-1:0] ack_timeout,
    input  logic          rx_pkt_valid,
    input  logic          rx_crc_ok,
    input  logic          rx_stored_ok,
    input  logic          ack_stb,
    input  logic          nak_stb,
    output logic          send_ack,
    output logic          send_nak,
    output logic          retransmit_req,
    output logic          xfer_done,
    output logic          xfer_fail,
    output logic          path_hold,
    output logic          held_path,
    output logic          cfg_err
);
    outcome_t outcome;

    pac_reply_gen u_reply (
        .clk       (clk),
        .rst       (rst),
        .pkt_valid (rx_pkt_valid),
        .crc_good  (rx_crc_ok),
        .stored    (rx_stored_ok),
        .reply_ack (send_ack),
        .reply_nak (send_nak)
    );

    pac_cfg_check #(
        .TW          (TW),
        .QS_CLKS     (QS_CLKS),
        .TURN_CLKS   (TURN_CLKS),
        .VERIFY_CLKS (VERIFY_CLKS)
    ) u_cfg (
        .timeout_len (ack_timeout),
        .too_short   (cfg_err)
    );

    pac_tx_tracker #(
        .TW        (TW),
        .MAX_RETRY (MAX_RETRY)
    ) u_tx (
        .clk         (clk),
        .rst         (rst),
        .start       (tx_start),
        .path_sel    (tx_path_sel),
        .send_done   (tx_done),
        .timeout_len (ack_timeout),
        .ack_in      (ack_stb),
        .nak_in      (nak_stb),
        .outcome     (outcome),
        .busy        (path_hold),
        .path_q      (held_path)
    );

    assign xfer_done      = outcome.done;
    assign retransmit_req = outcome.retx;
    assign xfer_fail      = outcome.fail;

endmodule

// File: tb/pkt_ack_ctrl_tb.sv
module pkt_ack_ctrl_tb;
    localparam int TW = 16;
    localparam int T  = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_start = 0, tx_path_sel = 0, tx_done = 0;
    logic [TW-1:0] ack_timeout = TW'(T);
    logic rx_pkt_valid = 0, rx_crc_ok = 0, rx_stored_ok = 0;
    logic ack_stb = 0, nak_stb = 0;
    logic send_ack, send_nak, retransmit_req, xfer_done, xfer_fail;
    logic path_hold, held_path, cfg_err;

    int n_checks = 0;
    int n_errs   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pkt_ack_ctrl u_dut (
        .clk(clk), .rst(rst), .tx_start(tx_start), .tx_path_sel(tx_path_sel),
        .tx_done(tx_done), .ack_timeout(ack_timeout), .rx_pkt_valid(rx_pkt_valid),
        .rx_crc_ok(rx_crc_ok), .rx_stored_ok(rx_stored_ok), .ack_stb(ack_stb),
        .nak_stb(nak_stb), .send_ack(send_ack), .send_nak(send_nak),
        .retransmit_req(retransmit_req), .xfer_done(xfer_done), .xfer_fail(xfer_fail),
        .path_hold(path_hold), .held_path(held_path), .cfg_err(cfg_err)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic start_tx(input logic p);
        tx_path_sel = p; tx_start = 1; tick(); tx_start = 0;
    endtask

    task automatic finish_send();
        tx_done = 1; tick(); tx_done = 0;
    endtask

    task automatic pulse_ack();
        ack_stb = 1; tick(); ack_stb = 0;
    endtask

    task automatic pulse_nak();
        nak_stb = 1; tick(); nak_stb = 0;
    endtask

    task automatic t_reset();
        check({send_ack, send_nak, retransmit_req, xfer_done, xfer_fail, path_hold} == 6'b0,
              "R7 reset outputs", int'({send_ack, send_nak, retransmit_req, xfer_done, xfer_fail, path_hold}), 0);
    endtask

    task automatic t_reply();
        rx_pkt_valid = 1; rx_crc_ok = 1; rx_stored_ok = 1; tick();
        rx_pkt_valid = 0;
        check(send_ack && !send_nak, "R1 ack reply", int'({send_ack, send_nak}), 2);
        tick();
        check(!send_ack, "R1 single pulse", int'(send_ack), 0);
        rx_pkt_valid = 1; rx_crc_ok = 1; rx_stored_ok = 0; tick();
        rx_pkt_valid = 0;
        check(send_nak && !send_ack, "R2 nak reply", int'({send_ack, send_nak}), 1);
        rx_pkt_valid = 1; rx_crc_ok = 0; rx_stored_ok = 1; tick();
        rx_pkt_valid = 0;
        check(!send_nak && !send_ack, "R3 crc fail silent", int'({send_ack, send_nak}), 0);
        rx_crc_ok = 0; rx_stored_ok = 0;
    endtask

    task automatic t_cfg();
        ack_timeout = TW'(15); #1;
        check(cfg_err == 1'b1, "R9 timeout 15 too short", int'(cfg_err), 1);
        ack_timeout = TW'(16); #1;
        check(cfg_err == 1'b0, "R9 timeout 16 accepted", int'(cfg_err), 0);
        ack_timeout = TW'(T); #1;
        check(cfg_err == 1'b0, "R9 timeout 20 accepted", int'(cfg_err), 0);
    endtask

    task automatic t_idle_strobes();
        pulse_ack();
        check(!xfer_done && !path_hold, "R8 ack while idle", int'({xfer_done, path_hold}), 0);
        pulse_nak();
        check(!retransmit_req && !xfer_fail, "R8 nak while idle", int'({retransmit_req, xfer_fail}), 0);
    endtask

    task automatic t_ack_done();
        start_tx(1'b1);
        check(path_hold && held_path, "R7 path latched", int'({path_hold, held_path}), 3);
        start_tx(1'b0);
        check(held_path == 1'b1, "R7 busy tx_start ignored", int'(held_path), 1);
        pulse_ack();
        check(!xfer_done && path_hold, "R8 ack while sending", int'({xfer_done, path_hold}), 1);
        finish_send();
        repeat (3) tick();
        pulse_ack();
        check(xfer_done && !path_hold, "R4 ack completes", int'({xfer_done, path_hold}), 2);
        tick();
        check(!xfer_done, "R4 done single pulse", int'(xfer_done), 0);
    endtask

    task automatic t_nak();
        start_tx(1'b0);
        finish_send();
        tick();
        pulse_nak();
        check(retransmit_req && path_hold && !held_path, "R5 nak retransmit",
              int'({retransmit_req, path_hold, held_path}), 6);
        pulse_ack();
        check(!xfer_done, "R8 ack before resend done", int'(xfer_done), 0);
        finish_send();
        pulse_ack();
        check(xfer_done, "R5 resend then ack", int'(xfer_done), 1);
    endtask

    task automatic t_timeout();
        bit early = 0;
        start_tx(1'b1);
        finish_send();
        for (int i = 1; i < T; i++) begin
            tick();
            if (retransmit_req) early = 1;
        end
        check(!early, "R6 no early expiry", int'(early), 0);
        tick();
        check(retransmit_req && path_hold, "R6 expiry retransmit", int'({retransmit_req, path_hold}), 3);
        finish_send();
        pulse_ack();
        check(xfer_done, "R6 recovers after expiry", int'(xfer_done), 1);
    endtask

    task automatic t_race();
        start_tx(1'b0);
        finish_send();
        repeat (T - 1) tick();
        pulse_ack();
        check(xfer_done && !retransmit_req, "R11 ack on final window cycle",
              int'({xfer_done, retransmit_req}), 2);
        start_tx(1'b1);
        finish_send();
        ack_stb = 1; nak_stb = 1; tick(); ack_stb = 0; nak_stb = 0;
        check(xfer_done && !retransmit_req, "R11 ack beats nak",
              int'({xfer_done, retransmit_req}), 2);
    endtask

    task automatic t_retry();
        bit bad = 0;
        start_tx(1'b1);
        for (int k = 0; k < 3; k++) begin
            finish_send();
            pulse_nak();
            if (!retransmit_req || xfer_fail) bad = 1;
        end
        check(!bad, "R10 retries below limit", int'(bad), 0);
        finish_send();
        pulse_nak();
        check(xfer_fail && !retransmit_req && !path_hold, "R10 limit fail",
              int'({xfer_fail, retransmit_req, path_hold}), 4);
        start_tx(1'b0);
        finish_send();
        pulse_nak();
        check(retransmit_req && !xfer_fail, "R10 count cleared by new start",
              int'({retransmit_req, xfer_fail}), 2);
        finish_send();
        pulse_ack();
    endtask

    initial begin
        repeat (3) tick();
        rst = 0;
        t_reset();
        t_reply();
        t_cfg();
        t_idle_strobes();
        t_ack_done();
        t_nak();
        t_timeout();
        t_race();
        t_retry();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_errs);
            $finish;
        end
    end

endmodule